// File: doc/BRIEF.md
# Instruction Skip-Pattern Sequencer

This controller sits beside the fetch and execute stages of a small pipelined core. Software loads a bit pattern in which bit k decides the fate of the k-th instruction that reaches execute after the load. Bit 0 is the head. In the cancelling mode each instruction that comes up uses one bit, and a 1 turns that instruction into a no-op. In the hopping mode the controller also tells fetch to advance the program counter past a whole run of 1 bits in one step. Those instructions are never fetched, so the skipped code costs no cycles.

A combined jump-and-skip command takes one operand. It issues a jump to the address in the low bits. The remaining upper bits become a hopping pattern that is applied from the jump target onwards. The command pushes no return address. Hopping is only safe while the instruction stream is sequential and local. When a loop is repeating, when code runs from external memory, or when a branch is in flight, the controller falls back to one bit per instruction. The set of instructions that actually execute is therefore the same in both modes, and only the number of cycles changes.

The control is a three-state machine: `SQ_IDLE` (no pattern), `SQ_SLOW` (cancelling) and `SQ_FAST` (hopping). It has four kinds of transition:
- LOAD_SLOW enters `SQ_SLOW`.
- LOAD_FAST and LOAD_JUMP enter `SQ_FAST`.
- RELOAD replaces a live pattern from either active state.
- DRAIN returns to `SQ_IDLE` once the pattern left after a step is all zero.

A load whose pattern is zero goes straight to `SQ_IDLE`.

Top module: `skip_seq`

## Requirements
- R1: After synchronous active-high reset there is no live pattern. `cancel_o` is 0, `pc_step_o` is 1 and `jump_go_o` is 0.
- R2: In cancelling mode, each real execute strobe uses exactly one bit, starting at bit 0. `cancel_o` equals that bit in the same cycle, and `pc_step_o` stays 1. With no strobe, `cancel_o` is 0.
- R3: In hopping mode, with no inhibit, a real strobe sets `cancel_o` to the head bit. It sets `pc_step_o` to 1 plus the count of consecutive 1 bits starting at bit 1. The pattern then moves down by that same amount.
- R4: While `loop_active_i` or `ext_exec_i` is high, a hopping pattern behaves exactly like a cancelling one: `pc_step_o` is 1 and one bit is used per strobe.
- R5: A strobe with `branch_busy_i` high marks the cancelled trailing slot of a branch. It uses no bit, drives `cancel_o` 0 and `pc_step_o` 1.
- R6: `load_jump_i` puts operand bits [9:0] on `jump_addr_o` and raises `jump_go_o` for exactly the next cycle. It loads operand bits [31:10] as a hopping pattern whose bit 0 applies to the instruction at the target.
- R7: Any load discards the previous pattern completely, whichever mode that pattern was in. Loads of different kinds arriving together are ranked jump, then hopping, then cancelling.
- R8: Once the remaining pattern is all zero, the block returns to idle. From then on strobes never cancel and `pc_step_o` is 1.
- R9: A strobe in the same cycle as a load belongs to the loading instruction. It uses no bit of the new pattern and is not cancelled.
- R10: Cycles without a strobe leave the pattern unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_slow_i | input | 1 | Load `operand_i` as a cancelling pattern |
| load_fast_i | input | 1 | Load `operand_i` as a hopping pattern |
| load_jump_i | input | 1 | Jump-and-skip: target in [9:0], hopping pattern in [31:10] |
| operand_i | input | 32 | Command operand |
| exec_strobe_i | input | 1 | An instruction slot reaches execute |
| branch_busy_i | input | 1 | The current slot is the trailing slot of a taken branch |
| loop_active_i | input | 1 | A repeat loop is running |
| ext_exec_i | input | 1 | Code is executing from external memory |
| cancel_o | output | 1 | Cancel the instruction now in execute |
| pc_step_o | output | 6 | Number of instruction addresses fetch advances by |
| jump_go_o | output | 1 | One-cycle jump request |
| jump_addr_o | output | 10 | Jump target |

## Verification
Some properties are checked by the assertions on every cycle:
- a branch trailing slot never cancels and never hops;
- an active loop or external execution forces a unit step;
- no strobe means no cancel and a held pattern;
- the jump request follows its command by one cycle with the right address;
- the block is quiet after reset.

Other behaviour can only be shown by the bench scenarios, which compare every strobe against an independent model:
- which instruction each pattern bit lands on;
- the exact hop lengths for various runs of 1 bits;
- discarding a live pattern on reload;
- the return to idle once the pattern drains;
- a long mixed sequence of branches, loops and external execution.

// File: rtl/skip_seq_pkg.sv
package skip_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SLOW = 2'd1,
        SQ_FAST = 2'd2
    } sq_state_e;

endpackage

// File: rtl/skip_run_count.sv
// Counts the consecutive 1 bits of a pattern starting at bit 1.
module skip_run_count #(
    parameter int PAT_W  = 32,
    parameter int STEP_W = 6
) (
    input  logic [PAT_W-1:0]  pat_i,
    output logic [STEP_W-1:0] run_o
);

    logic [PAT_W-1:0] alive;

    assign alive[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 1; gi < PAT_W; gi++) begin : g_chain
            if (gi == 1) begin : g_first
                assign alive[gi] = pat_i[gi];
            end else begin : g_rest
                assign alive[gi] = pat_i[gi] & alive[gi-1];
            end
        end
    endgenerate

    always_comb begin
        run_o = '0;
        for (int i = 1; i < PAT_W; i++) begin
            run_o = run_o + STEP_W'(alive[i]);
        end
    end

endmodule

// File: rtl/skip_pat_reg.sv
// Pattern register: load, shift down by a variable amount, or hold.
module skip_pat_reg #(
    parameter int PAT_W  = 32,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [PAT_W-1:0]  load_val_i,
    input  logic              shift_i,
    input  logic [STEP_W-1:0] amt_i,
    output logic [PAT_W-1:0]  pat_o,
    output logic [PAT_W-1:0]  after_o
);

    logic [PAT_W-1:0] pat_q;

    assign after_o = pat_q >> amt_i;
    assign pat_o   = pat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
        end else if (load_i) begin
            pat_q <= load_val_i;
        end else if (shift_i) begin
            pat_q <= after_o;
        end
    end

endmodule

// File: rtl/skip_fsm.sv
// Mode state machine: idle, cancelling, hopping.
module skip_fsm
    import skip_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ld_slow_i,
    input  logic      ld_fast_i,
    input  logic      ld_zero_i,
    input  logic      strobe_i,
    input  logic      branch_i,
    input  logic      inhibit_i,
    input  logic      head_i,
    input  logic      after_zero_i,
    output sq_state_e state_o,
    output logic      consume_o,
    output logic      cancel_o,
    output logic      hop_o
);

    sq_state_e state_q, state_d;
    logic      any_ld;

    assign any_ld  = ld_slow_i | ld_fast_i;
    assign state_o = state_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ld_fast_i) begin
            state_d = ld_zero_i ? SQ_IDLE : SQ_FAST;
        end else if (ld_slow_i) begin
            state_d = ld_zero_i ? SQ_IDLE : SQ_SLOW;
        end else begin
            unique case (state_q)
                SQ_IDLE: state_d = SQ_IDLE;
                SQ_SLOW,
                SQ_FAST: begin
                    if (consume_o && after_zero_i) begin
                        state_d = SQ_IDLE;
                    end
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        consume_o = 1'b0;
        cancel_o  = 1'b0;
        hop_o     = 1'b0;
        unique case (state_q)
            SQ_IDLE: ;
            SQ_SLOW: begin
                consume_o = strobe_i && !branch_i && !any_ld;
                cancel_o  = consume_o && head_i;
            end
            SQ_FAST: begin
                consume_o = strobe_i && !branch_i && !any_ld;
                cancel_o  = consume_o && head_i;
                hop_o     = consume_o && !inhibit_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/skip_seq.sv
// Skip-pattern sequencer top.
module skip_seq
    import skip_seq_pkg::*;
#(
    parameter int OP_W   = 32,
    parameter int ADDR_W = 10,
    parameter int PAT_W  = OP_W,
    parameter int STEP_W = $clog2(PAT_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_slow_i,
    input  logic              load_fast_i,
    input  logic              load_jump_i,
    input  logic [OP_W-1:0]   operand_i,
    input  logic              exec_strobe_i,
    input  logic              branch_busy_i,
    input  logic              loop_active_i,
    input  logic              ext_exec_i,
    output logic              cancel_o,
    output logic [STEP_W-1:0] pc_step_o,
    output logic              jump_go_o,
    output logic [ADDR_W-1:0] jump_addr_o
);

    localparam int JPAT_W = OP_W - ADDR_W;

    sq_state_e         state;
    logic              consume, hop;
    logic              ld_fast, ld_slow, any_load;
    logic [PAT_W-1:0]  load_val, pat_q, pat_after;
    logic [STEP_W-1:0] run, amt;
    logic              jump_go_q;
    logic [ADDR_W-1:0] jump_addr_q;

    assign ld_fast  = load_fast_i | load_jump_i;
    assign ld_slow  = load_slow_i & ~ld_fast;
    assign any_load = ld_fast | ld_slow;

    always_comb begin
        if (load_jump_i) begin
            load_val = PAT_W'(operand_i[OP_W-1:ADDR_W]);
        end else begin
            load_val = PAT_W'(operand_i);
        end
    end

    skip_run_count #(.PAT_W(PAT_W), .STEP_W(STEP_W)) run_i (
        .pat_i (pat_q),
        .run_o (run)
    );

    assign amt = hop ? (run + STEP_W'(1)) : STEP_W'(1);

    skip_pat_reg #(.PAT_W(PAT_W), .STEP_W(STEP_W)) pat_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (any_load),
        .load_val_i (load_val),
        .shift_i    (consume),
        .amt_i      (amt),
        .pat_o      (pat_q),
        .after_o    (pat_after)
    );

    skip_fsm fsm_i (
        .clk          (clk),
        .rst          (rst),
        .ld_slow_i    (ld_slow),
        .ld_fast_i    (ld_fast),
        .ld_zero_i    (load_val == '0),
        .strobe_i     (exec_strobe_i),
        .branch_i     (branch_busy_i),
        .inhibit_i    (loop_active_i | ext_exec_i),
        .head_i       (pat_q[0]),
        .after_zero_i (pat_after == '0),
        .state_o      (state),
        .consume_o    (consume),
        .cancel_o     (cancel_o),
        .hop_o        (hop)
    );

    assign pc_step_o = amt;

    always_ff @(posedge clk) begin
        if (rst) begin
            jump_go_q   <= 1'b0;
            jump_addr_q <= '0;
        end else begin
            jump_go_q <= load_jump_i;
            if (load_jump_i) begin
                jump_addr_q <= operand_i[ADDR_W-1:0];
            end
        end
    end

    assign jump_go_o   = jump_go_q;
    assign jump_addr_o = jump_addr_q;

endmodule

// File: rtl/skip_seq_chk.sv
module skip_seq_chk #(
    parameter int OP_W   = 32,
    parameter int ADDR_W = 10,
    parameter int PAT_W  = 32,
    parameter int STEP_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              load_jump_i,
    input logic [OP_W-1:0]   operand_i,
    input logic              exec_strobe_i,
    input logic              branch_busy_i,
    input logic              loop_active_i,
    input logic              ext_exec_i,
    input logic              any_load,
    input logic [PAT_W-1:0]  pat_q,
    input logic              cancel_o,
    input logic [STEP_W-1:0] pc_step_o,
    input logic              jump_go_o,
    input logic [ADDR_W-1:0] jump_addr_o
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (pc_step_o == STEP_W'(1) && !jump_go_o)); // R1

    AST_IDLE_NO_CANCEL: assert property (@(posedge clk) disable iff (rst)
        !exec_strobe_i |-> !cancel_o); // R2

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (pc_step_o >= STEP_W'(1)) && (pc_step_o <= STEP_W'(PAT_W))); // R3

    AST_INHIBIT_UNIT: assert property (@(posedge clk) disable iff (rst)
        (loop_active_i || ext_exec_i) |-> pc_step_o == STEP_W'(1)); // R4

    AST_TRAIL_SLOT: assert property (@(posedge clk) disable iff (rst)
        (exec_strobe_i && branch_busy_i) |-> (!cancel_o && pc_step_o == STEP_W'(1))); // R5

    AST_JUMP_PULSE: assert property (@(posedge clk) disable iff (rst)
        load_jump_i |=> (jump_go_o && jump_addr_o == $past(operand_i[ADDR_W-1:0]))); // R6

    AST_PATTERN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!exec_strobe_i && !any_load) |=> $stable(pat_q)); // R10

endmodule

bind skip_seq skip_seq_chk #(
    .OP_W(OP_W), .ADDR_W(ADDR_W), .PAT_W(PAT_W), .STEP_W(STEP_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .load_jump_i   (load_jump_i),
    .operand_i     (operand_i),
    .exec_strobe_i (exec_strobe_i),
    .branch_busy_i (branch_busy_i),
    .loop_active_i (loop_active_i),
    .ext_exec_i    (ext_exec_i),
    .any_load      (any_load),
    .pat_q         (pat_q),
    .cancel_o      (cancel_o),
    .pc_step_o     (pc_step_o),
    .jump_go_o     (jump_go_o),
    .jump_addr_o   (jump_addr_o)
);

// File: tb/skip_seq_tb_top.sv
`timescale 1ns/1ps
module skip_seq_tb_top;

    localparam int OP_W = 32;
    localparam int ADDR_W = 10;
    localparam int STEP_W = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_slow_i = 0, load_fast_i = 0, load_jump_i = 0;
    logic [OP_W-1:0]   operand_i = '0;
    logic              exec_strobe_i = 0, branch_busy_i = 0;
    logic              loop_active_i = 0, ext_exec_i = 0;
    logic              cancel_o;
    logic [STEP_W-1:0] pc_step_o;
    logic              jump_go_o;
    logic [ADDR_W-1:0] jump_addr_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model
    logic [OP_W-1:0] m_pat = '0;
    int              m_mode = 0; // 0 idle, 1 cancelling, 2 hopping

    always #10 clk = ~clk;

    skip_seq dut_i (
        .clk(clk), .rst(rst),
        .load_slow_i(load_slow_i), .load_fast_i(load_fast_i), .load_jump_i(load_jump_i),
        .operand_i(operand_i),
        .exec_strobe_i(exec_strobe_i), .branch_busy_i(branch_busy_i),
        .loop_active_i(loop_active_i), .ext_exec_i(ext_exec_i),
        .cancel_o(cancel_o), .pc_step_o(pc_step_o),
        .jump_go_o(jump_go_o), .jump_addr_o(jump_addr_o)
    );

    function automatic int lead_run(input logic [OP_W-1:0] p);
        int n = 0;
        for (int i = 1; i < OP_W; i++) begin
            if (!p[i]) break;
            n++;
        end
        return n;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one execute step: drive, check against the model, advance the model
    task automatic step(input bit strobe, input bit br, input bit loop, input bit ext, input string tag);
        int  e_step;
        bit  e_cancel;
        bit  real_slot;
        @(negedge clk);
        exec_strobe_i = strobe; branch_busy_i = br;
        loop_active_i = loop;   ext_exec_i = ext;
        load_slow_i = 0; load_fast_i = 0; load_jump_i = 0;
        #2;
        real_slot = strobe && !br && (m_mode != 0);
        e_cancel  = real_slot && m_pat[0];
        e_step    = (real_slot && m_mode == 2 && !loop && !ext) ? 1 + lead_run(m_pat) : 1;
        check(tag, "cancel", int'(cancel_o), int'(e_cancel));
        check(tag, "pc_step", int'(pc_step_o), e_step);
        if (real_slot) begin
            m_pat = m_pat >> e_step;
            if (m_pat == '0) m_mode = 0;
        end
    endtask

    // kind: 1 cancelling, 2 hopping, 3 jump-and-skip
    task automatic load(input int kind, input logic [OP_W-1:0] op, input bit strobe, input string tag);
        @(negedge clk);
        exec_strobe_i = strobe; branch_busy_i = 0;
        load_slow_i = (kind == 1); load_fast_i = (kind == 2); load_jump_i = (kind == 3);
        operand_i = op;
        #2;
        check(tag, "cancel on load", int'(cancel_o), 0);
        m_pat  = (kind == 3) ? {{ADDR_W{1'b0}}, op[OP_W-1:ADDR_W]} : op;
        m_mode = (m_pat == '0) ? 0 : ((kind == 1) ? 1 : 2);
        @(negedge clk);
        load_slow_i = 0; load_fast_i = 0; load_jump_i = 0; exec_strobe_i = 0;
        #2;
        if (kind == 3) begin
            check(tag, "jump_go", int'(jump_go_o), 1);
            check(tag, "jump_addr", int'(jump_addr_o), int'(op[ADDR_W-1:0]));
        end else begin
            check(tag, "jump_go idle", int'(jump_go_o), 0);
        end
    endtask

    task automatic t_reset();
        check("R1", "cancel", int'(cancel_o), 0);
        check("R1", "pc_step", int'(pc_step_o), 1);
        check("R1", "jump_go", int'(jump_go_o), 0);
        step(1, 0, 0, 0, "R1");
    endtask

    task automatic t_slow();
        load(1, 32'b1011_0110, 0, "R2");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, "R2");
        step(0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R8"); // drained: no cancel
        check("R8", "idle cancel", int'(cancel_o), 0);
    endtask

    task automatic t_fast();
        load(2, 32'b1111_0111_0110, 0, "R3");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, "R8");
        load(2, 32'hFFFF_FFFE, 0, "R3"); // longest run
        step(1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, "R8");
    endtask

    task automatic t_inhibit();
        load(2, 32'b0111_0110, 0, "R4");
        step(1, 0, 1, 0, "R4");
        step(1, 0, 1, 0, "R4");
        step(1, 0, 0, 1, "R4");
        step(1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, "R4");
    endtask

    task automatic t_branch();
        load(1, 32'b1101, 0, "R5");
        step(1, 0, 0, 0, "R5");
        step(1, 1, 0, 0, "R5");
        step(1, 0, 0, 0, "R5");
        step(1, 1, 0, 0, "R5");
        step(1, 0, 0, 0, "R5");
        load(2, 32'b0111_0110, 0, "R5");
        step(1, 1, 0, 0, "R5");
        step(1, 0, 0, 0, "R5");
        step(1, 0, 0, 0, "R5");
    endtask

    task automatic t_jump();
        load(3, {22'b10_0110, 10'h2A5}, 0, "R6");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R6");
        load(3, 32'h0000_0155, 0, "R6"); // empty pattern
        step(1, 0, 0, 0, "R6");
    endtask

    task automatic t_reload();
        load(1, 32'b1111, 0, "R7");
        step(1, 0, 0, 0, "R7");
        load(2, 32'b0110, 0, "R7");
        step(1, 0, 0, 0, "R7");
        step(1, 0, 0, 0, "R7");
        load(1, 32'b0101, 0, "R7");
        load(1, 32'b0000, 0, "R7");
        step(1, 0, 0, 0, "R7");
    endtask

    task automatic t_load_strobe();
        load(1, 32'b101, 1, "R9");
        step(1, 0, 0, 0, "R9");
        step(1, 0, 0, 0, "R9");
        step(1, 0, 0, 0, "R9");
    endtask

    task automatic t_hold();
        load(1, 32'b10, 0, "R10");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R10");
        step(1, 0, 0, 0, "R10");
        step(0, 0, 0, 0, "R10");
        step(1, 0, 0, 0, "R10");
    endtask

    task automatic t_mixed();
        logic [31:0] lf = 32'hACE1_5A3C;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (lf[7:4] == 4'h3) load(1, lf ^ 32'h5A5A_0F0F, 0, "R7");
            else if (lf[7:4] == 4'h9) load(2, lf ^ 32'h3C3C_F00F, lf[8], "R3");
            else if (lf[7:4] == 4'hC) load(3, lf, 0, "R6");
            else step(lf[0] | lf[1], lf[2] & lf[3], lf[9] & lf[10], lf[11] & lf[12], "R4");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        t_reset();
        t_slow();
        t_fast();
        t_inhibit();
        t_branch();
        t_jump();
        t_reload();
        t_load_strobe();
        t_hold();
        t_mixed();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule